// File: doc/BRIEF.md
# Open-Row Bank Command Controller

This block sits between an in-order stream of memory read and write requests and a DRAM device made of 32 independent banks (eight groups of four). Each request carries a flat 31-bit address. The controller remembers which row, if any, is open in every bank. For each request it issues only the commands that request needs. A request to the open row gets a single column command. A request to a bank with nothing open gets an activate and then the column command. A request to a bank that has a different row open gets a precharge, then an activate, then the column command.

Commands go out one per cycle at most, on a registered command port. An activate carries the bank group, the bank and the row. The column command that follows carries the column. Each bank has its own counters for the activate-to-column, precharge-to-activate and activate-to-precharge windows, and the controller holds a command back until those counters allow it. A pulse marks the cycle in which read data should arrive, a fixed number of cycles after each read command. Two running counters report how requests were classified.

Top module: `open_row_ctrl`

## Requirements
- R1: Address fields are bank group = `req_addr[30:28]`, bank = `req_addr[27:26]`, row = `req_addr[25:10]` and column = `req_addr[9:0]`. An activate puts the row on `cmd_addr`. A read or write puts the column, zero-extended, on `cmd_addr`. Every command carries its bank on `cmd_bg`/`cmd_bank`.
- R2: A request whose bank has the same row open produces exactly one column command: `cmd_kind` 2'b10 for a read or 2'b11 for a write. It also increments `hit_count` by one.
- R3: A request to a bank with no open row produces an activate (`cmd_kind` 2'b00) and then the column command, with no precharge. It increments `miss_count` by one.
- R4: A request to a bank that has a different row open produces, in this order, a precharge (`cmd_kind` 2'b01) of that bank, an activate of the new row and the column command. It increments `miss_count` by one. No activate is ever issued to a bank that already has an open row.
- R5: Banks keep their open rows independently. Activating or precharging one bank never closes a row in another bank.
- R6: A column command to a bank comes at least T_RCD cycles after that bank's activate. When nothing else delays it, it comes exactly T_RCD cycles after.
- R7: An activate to a bank comes at least T_RP cycles after that bank's last precharge. After a precharge issued for a row conflict, the activate comes exactly T_RP cycles after it.
- R8: A precharge to a bank comes at least T_RAS cycles after that bank's last activate.
- R9: `rd_expect` pulses for one cycle exactly CL cycles after each read command. It never pulses for writes.
- R10: Requests are served one at a time and in order. `req_ready` is low from the cycle after acceptance until the request's column command has been issued.
- R11: After reset no bank has an open row, `req_ready` is high, `cmd_valid` and `rd_expect` are low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Flat address {group, bank, row, column} |
| cmd_valid | output | 1 | A command is on the command port this cycle |
| cmd_kind | output | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| cmd_bg | output | 3 | Bank group of the command |
| cmd_bank | output | 2 | Bank within the group |
| cmd_addr | output | 16 | Row for activate, zero-extended column for read/write |
| rd_expect | output | 1 | Read data due this cycle |
| hit_count | output | 16 | Number of requests that were row hits |
| miss_count | output | 16 | Number of requests that needed an activate |

## Verification
The checker watches the command port on every cycle and keeps its own per-bank record of open rows and elapsed cycles. From that record it checks the three timing minimums and that a column command only goes to an open bank. It also checks that an activate never targets a bank that is already open, and that only one request is in flight at a time. The bench scenarios are needed for the rest: the exact command order chosen for hit, closed and conflict cases, the address fields carried by each command, the exact (not just minimum) spacing on the fast path, the read-data pulse position, and the classification counters.

// File: rtl/orc_pkg.sv
`timescale 1ns/1ps
package orc_pkg;
   typedef enum logic [1:0] {
      CMD_ACT = 2'b00,
      CMD_PRE = 2'b01,
      CMD_RD  = 2'b10,
      CMD_WR  = 2'b11
   } cmd_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_PRE  = 2'b01,
      SQ_ACT  = 2'b10,
      SQ_COL  = 2'b11
   } seq_state_e;
endpackage

// File: rtl/orc_bank_track.sv
`timescale 1ns/1ps
// Per-bank open-row record and timing window counters.
module orc_bank_track #(
   parameter int ROW_W = 16,
   parameter int CNT_W = 4,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             pre_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             col_ok_o,
   output logic             act_ok_o,
   output logic             pre_ok_o
);
   localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(T_RAS - 1);

   logic [CNT_W-1:0] rcd_q, rp_q, ras_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
         rcd_q  <= '0;
         rp_q   <= '0;
         ras_q  <= '0;
      end else begin
         if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
            rcd_q  <= RCD_LD;
            ras_q  <= RAS_LD;
         end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
         end
         if (pre_i) begin
            open_o <= 1'b0;
            rp_q   <= RP_LD;
         end else if (rp_q != '0) begin
            rp_q <= rp_q - 1'b1;
         end
      end
   end

   assign col_ok_o = (rcd_q == '0);
   assign act_ok_o = (rp_q == '0);
   assign pre_ok_o = (ras_q == '0);
endmodule

// File: rtl/orc_sequencer.sv
`timescale 1ns/1ps
// In-order request sequencer: classifies on acceptance, then walks
// precharge / activate / column states as the bank counters allow.
module orc_sequencer
   import orc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic sel_open,
   input  logic sel_match,
   input  logic sel_col_ok,
   input  logic sel_act_ok,
   input  logic sel_pre_ok,
   output logic ready,
   output logic issue_pre,
   output logic issue_act,
   output logic issue_col,
   output logic cls_hit,
   output logic cls_miss
);
   seq_state_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      issue_pre = 1'b0;
      issue_act = 1'b0;
      issue_col = 1'b0;
      cls_hit   = 1'b0;
      cls_miss  = 1'b0;
      ready     = (st_q == SQ_IDLE);
      unique case (st_q)
         SQ_IDLE: if (req_valid) begin
            if (sel_open && sel_match) begin
               cls_hit = 1'b1;
               st_d    = SQ_COL;
            end else begin
               cls_miss = 1'b1;
               st_d     = sel_open ? SQ_PRE : SQ_ACT;
            end
         end
         SQ_PRE: if (sel_pre_ok) begin
            issue_pre = 1'b1;
            st_d      = SQ_ACT;
         end
         SQ_ACT: if (sel_act_ok) begin
            issue_act = 1'b1;
            st_d      = SQ_COL;
         end
         SQ_COL: if (sel_col_ok) begin
            issue_col = 1'b1;
            st_d      = SQ_IDLE;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/orc_lat_pipe.sv
`timescale 1ns/1ps
// Fixed-latency marker pipe for read-data timing.
module orc_lat_pipe #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic out_o
);
   generate
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) out_o <= 1'b0;
            else        out_o <= in_i;
         end
      end else begin : g_shift
         logic [DEPTH-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[DEPTH-2:0], in_i};
         end
         assign out_o = sr_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/open_row_ctrl.sv
`timescale 1ns/1ps
module open_row_ctrl
   import orc_pkg::*;
#(
   parameter int BG_W   = 3,
   parameter int BK_W   = 2,
   parameter int ROW_W  = 16,
   parameter int COL_W  = 10,
   parameter int CL     = 4,
   parameter int T_RCD  = 3,
   parameter int T_RP   = 3,
   parameter int T_RAS  = 8,
   parameter int STAT_W = 16,
   localparam int ADDR_W = BG_W + BK_W + ROW_W + COL_W,
   localparam int CMDA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [BG_W-1:0]   cmd_bg,
   output logic [BK_W-1:0]   cmd_bank,
   output logic [CMDA_W-1:0] cmd_addr,
   output logic              rd_expect,
   output logic [STAT_W-1:0] hit_count,
   output logic [STAT_W-1:0] miss_count
);
   localparam int BANK_W = BG_W + BK_W;
   localparam int NBANK  = 1 << BANK_W;
   localparam int T_MAX  = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                           : ((T_RCD > T_RP) ? T_RCD : T_RP);
   localparam int CNT_W  = $clog2(T_MAX + 1);

   generate
      if (T_RCD < 1 || T_RP < 1 || T_RAS < 1) begin : g_bad_timing
         $error("timing windows must be at least one cycle");
      end
      if (CL < 1) begin : g_bad_cl
         $error("CL must be at least one cycle");
      end
      if (BANK_W > 8) begin : g_bad_banks
         $error("bank count too large for the per-bank tracker array");
      end
   endgenerate

   // request field split
   logic [BANK_W-1:0] req_bank;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;
   assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
   assign req_row  = req_addr[COL_W +: ROW_W];
   assign req_col  = req_addr[COL_W-1:0];

   // latched in-flight request
   logic              cur_write;
   logic [BANK_W-1:0] cur_bank;
   logic [ROW_W-1:0]  cur_row;
   logic [COL_W-1:0]  cur_col;

   logic issue_pre, issue_act, issue_col, cls_hit, cls_miss;
   logic req_fire;
   assign req_fire = req_valid && req_ready;

   // bank array
   logic [NBANK-1:0] b_open, b_col_ok, b_act_ok, b_pre_ok, b_act, b_pre;
   logic [ROW_W-1:0] b_row [NBANK];

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         assign b_act[b] = issue_act && (cur_bank == BANK_W'(b));
         assign b_pre[b] = issue_pre && (cur_bank == BANK_W'(b));
         orc_bank_track #(
            .ROW_W(ROW_W), .CNT_W(CNT_W),
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
         ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (b_act[b]),
            .pre_i    (b_pre[b]),
            .row_i    (cur_row),
            .open_o   (b_open[b]),
            .row_o    (b_row[b]),
            .col_ok_o (b_col_ok[b]),
            .act_ok_o (b_act_ok[b]),
            .pre_ok_o (b_pre_ok[b])
         );
      end
   endgenerate

   // bank selection: incoming request while idle, in-flight one otherwise
   logic [BANK_W-1:0] sel_bank;
   logic              sel_match;
   assign sel_bank  = req_ready ? req_bank : cur_bank;
   assign sel_match = (b_row[sel_bank] == req_row);

   orc_sequencer u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .sel_open   (b_open[sel_bank]),
      .sel_match  (sel_match),
      .sel_col_ok (b_col_ok[sel_bank]),
      .sel_act_ok (b_act_ok[sel_bank]),
      .sel_pre_ok (b_pre_ok[sel_bank]),
      .ready      (req_ready),
      .issue_pre  (issue_pre),
      .issue_act  (issue_act),
      .issue_col  (issue_col),
      .cls_hit    (cls_hit),
      .cls_miss   (cls_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_write <= 1'b0;
         cur_bank  <= '0;
         cur_row   <= '0;
         cur_col   <= '0;
      end else if (req_fire) begin
         cur_write <= req_write;
         cur_bank  <= req_bank;
         cur_row   <= req_row;
         cur_col   <= req_col;
      end
   end

   // command register
   logic [CMDA_W-1:0] row_ext, col_ext;
   always_comb begin
      row_ext = '0;
      row_ext[ROW_W-1:0] = cur_row;
      col_ext = '0;
      col_ext[COL_W-1:0] = cur_col;
   end

   cmd_kind_e kind_d;
   always_comb begin
      if (issue_pre)      kind_d = CMD_PRE;
      else if (issue_act) kind_d = CMD_ACT;
      else if (cur_write) kind_d = CMD_WR;
      else                kind_d = CMD_RD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_kind  <= CMD_ACT;
         cmd_bg    <= '0;
         cmd_bank  <= '0;
         cmd_addr  <= '0;
      end else begin
         cmd_valid <= issue_pre || issue_act || issue_col;
         if (issue_pre || issue_act || issue_col) begin
            cmd_kind <= kind_d;
            cmd_bg   <= cur_bank[BANK_W-1 -: BG_W];
            cmd_bank <= cur_bank[BK_W-1:0];
            cmd_addr <= issue_col ? col_ext : row_ext;
         end
      end
   end

   // classification counters
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         if (cls_hit)  hit_count  <= hit_count + 1'b1;
         if (cls_miss) miss_count <= miss_count + 1'b1;
      end
   end

   orc_lat_pipe #(.DEPTH(CL)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (cmd_valid && (cmd_kind == CMD_RD)),
      .out_o (rd_expect)
   );
endmodule

// File: rtl/orc_checker.sv
`timescale 1ns/1ps
module orc_checker #(
   parameter int BG_W  = 3,
   parameter int BK_W  = 2,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3,
   parameter int T_RAS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            cmd_valid,
   input logic [1:0]      cmd_kind,
   input logic [BG_W-1:0] cmd_bg,
   input logic [BK_W-1:0] cmd_bank
);
   localparam int BANK_W = BG_W + BK_W;
   localparam int NBANK  = 1 << BANK_W;
   localparam logic [7:0] SAT = 8'hFF;

   logic [7:0]       since_act [NBANK];
   logic [7:0]       since_pre [NBANK];
   logic [NBANK-1:0] seen_open;
   logic [BANK_W-1:0] idx;
   assign idx = {cmd_bg, cmd_bank};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_open <= '0;
         for (int b = 0; b < NBANK; b++) begin
            since_act[b] <= SAT;
            since_pre[b] <= SAT;
         end
      end else begin
         for (int b = 0; b < NBANK; b++) begin
            if (cmd_valid && idx == BANK_W'(b) && cmd_kind == 2'b00) begin
               since_act[b] <= 8'd1;
               seen_open[b] <= 1'b1;
            end else if (since_act[b] != SAT) begin
               since_act[b] <= since_act[b] + 8'd1;
            end
            if (cmd_valid && idx == BANK_W'(b) && cmd_kind == 2'b01) begin
               since_pre[b] <= 8'd1;
               seen_open[b] <= 1'b0;
            end else if (since_pre[b] != SAT) begin
               since_pre[b] <= since_pre[b] + 8'd1;
            end
         end
      end
   end

   AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind[1]) |-> (since_act[idx] >= 8'(T_RCD))); // R6
   AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'b00) |-> (since_pre[idx] >= 8'(T_RP))); // R7
   AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'b01) |-> (since_act[idx] >= 8'(T_RAS))); // R8
   AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind[1]) |-> seen_open[idx]); // R2
   AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'b00) |-> !seen_open[idx]); // R4
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R10
endmodule

bind open_row_ctrl orc_checker #(
   .BG_W(BG_W), .BK_W(BK_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .cmd_valid (cmd_valid),
   .cmd_kind  (cmd_kind),
   .cmd_bg    (cmd_bg),
   .cmd_bank  (cmd_bank)
);

// File: tb/open_row_ctrl_test.sv
`timescale 1ns/1ps
module open_row_ctrl_test;
   localparam int CL    = 4;
   localparam int T_RCD = 3;
   localparam int T_RP  = 3;
   localparam int T_RAS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [30:0] req_addr = '0;
   logic        cmd_valid;
   logic [1:0]  cmd_kind;
   logic [2:0]  cmd_bg;
   logic [1:0]  cmd_bank;
   logic [15:0] cmd_addr;
   logic        rd_expect;
   logic [15:0] hit_count, miss_count;

   always #2.5 clk = ~clk;

   open_row_ctrl #(.CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_bg(cmd_bg), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .rd_expect(rd_expect), .hit_count(hit_count),
      .miss_count(miss_count)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // command monitor and read-data pulse model
   int q_kind[$];
   int q_bank[$];
   int q_addr[$];
   int q_cyc[$];
   int q_rd[$];

   always @(negedge clk) begin
      bit exp_now;
      exp_now = (q_rd.size() > 0) && (q_rd[0] == cyc);
      if (exp_now) void'(q_rd.pop_front());
      if (exp_now || rd_expect) chk(rd_expect == exp_now, "R9", "rd_expect", rd_expect, exp_now);
      else if (rd_expect !== 1'b0) chk(1'b0, "R9", "rd_expect", rd_expect, 0);
      if (cmd_valid === 1'b1) begin
         q_kind.push_back(int'(cmd_kind));
         q_bank.push_back(int'({cmd_bg, cmd_bank}));
         q_addr.push_back(int'(cmd_addr));
         q_cyc.push_back(cyc);
         if (cmd_kind == 2'b10) q_rd.push_back(cyc + CL);
      end
   end

   // bench model of the banks
   bit          m_open [32];
   int          m_row  [32];
   int          m_act  [32];
   int          m_pre  [32];
   int          exp_hit = 0;
   int          exp_miss = 0;

   function automatic int exp_class(input int bk, input int row);
      if (!m_open[bk]) return 1;          // closed
      if (m_row[bk] == row) return 0;     // hit
      return 2;                           // conflict
   endfunction

   task automatic do_req(input bit wr, input logic [30:0] addr);
      int bk, row, col, cls, nexp, k, act_c, pre_c, col_c;
      bk  = int'(addr[30:26]);
      row = int'(addr[25:10]);
      col = int'(addr[9:0]);
      cls = exp_class(bk, row);
      nexp = (cls == 0) ? 1 : ((cls == 1) ? 2 : 3);
      if (cls == 0) exp_hit++; else exp_miss++;

      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10", "ready low while busy", req_ready, 0);
      while (q_kind.size() < nexp) @(posedge clk);

      k = 0;
      act_c = -1;
      if (cls == 2) begin
         chk(q_kind[0] == 1, "R4", "first cmd precharge", q_kind[0], 1);
         chk(q_bank[0] == bk, "R4", "precharge bank", q_bank[0], bk);
         chk(q_cyc[0] - m_act[bk] >= T_RAS, "R8", "act->pre gap", q_cyc[0] - m_act[bk], T_RAS);
         pre_c = q_cyc[0];
         m_pre[bk] = pre_c;
         k = 1;
         chk(q_cyc[1] - pre_c == T_RP, "R7", "pre->act gap", q_cyc[1] - pre_c, T_RP);
      end
      if (cls != 0) begin
         chk(q_kind[k] == 0, (cls == 1) ? "R3" : "R4", "activate kind", q_kind[k], 0);
         chk(q_bank[k] == bk, "R1", "activate bank", q_bank[k], bk);
         chk(q_addr[k] == row, "R1", "activate row", q_addr[k], row);
         chk(q_cyc[k] - m_pre[bk] >= T_RP, "R7", "pre->act min", q_cyc[k] - m_pre[bk], T_RP);
         act_c = q_cyc[k];
         m_act[bk] = act_c;
         k++;
      end
      col_c = q_cyc[k];
      chk(q_kind[k] == (wr ? 3 : 2), (cls == 0) ? "R2" : "R3", "column kind", q_kind[k], wr ? 3 : 2);
      chk(q_bank[k] == bk, "R1", "column bank", q_bank[k], bk);
      chk(q_addr[k] == col, "R1", "column addr", q_addr[k], col);
      if (act_c >= 0) chk(col_c - act_c == T_RCD, "R6", "act->col gap", col_c - act_c, T_RCD);
      else chk(col_c - m_act[bk] >= T_RCD, "R6", "act->col min", col_c - m_act[bk], T_RCD);
      for (int j = 0; j < nexp; j++) begin
         void'(q_kind.pop_front()); void'(q_bank.pop_front());
         void'(q_addr.pop_front()); void'(q_cyc.pop_front());
      end
      m_open[bk] = 1'b1;
      m_row[bk]  = row;
      @(negedge clk);
      chk(hit_count == 16'(exp_hit), "R2", "hit_count", hit_count, exp_hit);
      chk(miss_count == 16'(exp_miss), "R3", "miss_count", miss_count, exp_miss);
      chk(q_kind.size() == 0, "R10", "no extra commands", q_kind.size(), 0);
   endtask

   function automatic logic [30:0] mk(input int bk, input int row, input int col);
      return {5'(bk), 16'(row), 10'(col)};
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int b = 0; b < 32; b++) begin
         m_open[b] = 1'b0; m_row[b] = 0; m_act[b] = -1000; m_pre[b] = -1000;
      end
      void'($urandom(32'd1234));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
      chk(cmd_valid == 1'b0, "R11", "cmd_valid after reset", cmd_valid, 0);
      chk(rd_expect == 1'b0, "R11", "rd_expect after reset", rd_expect, 0);
      chk(hit_count == 0 && miss_count == 0, "R11", "counters after reset",
          hit_count + miss_count, 0);

      // directed: closed, hit, conflict, write, independence, extreme fields
      do_req(1'b0, mk(0, 16'h1234, 10'h005));   // R3 closed bank
      do_req(1'b0, mk(0, 16'h1234, 10'h3FF));   // R2 hit immediately
      do_req(1'b1, mk(0, 16'h1234, 10'h000));   // R2 write hit, R9 no pulse
      do_req(1'b0, mk(0, 16'h0042, 10'h011));   // R4 conflict, R8 tRAS wait
      do_req(1'b0, mk(5, 16'hBEEF, 10'h222));   // R5 second bank
      do_req(1'b0, mk(0, 16'h0042, 10'h012));   // R5 bank 0 still open
      do_req(1'b1, mk(5, 16'hBEEF, 10'h001));   // R5 bank 5 still open
      do_req(1'b0, mk(31, 16'hFFFF, 10'h3FF));  // R1 all-ones fields
      do_req(1'b0, mk(31, 16'h0000, 10'h000));  // R4 conflict on top bank

      // constrained random mix
      for (int i = 0; i < 250; i++) begin
         int bk, row, sel;
         sel = int'($urandom % 4);
         bk  = (sel == 0) ? int'($urandom % 32) : int'(($urandom % 4) * 9 % 32);
         case (int'($urandom % 4))
            0: row = 0;
            1: row = 1;
            2: row = 16'hFFFF;
            default: row = int'($urandom % 65536);
         endcase
         do_req(1'($urandom % 2), mk(bk, row, int'($urandom % 1024)));
      end

      repeat (CL + 6) @(negedge clk);
      chk(q_rd.size() == 0, "R9", "all read pulses seen", q_rd.size(), 0);
      finish_run();
   end
endmodule